// File: doc/BRIEF.md
# Seven-Symbol Word Codec with Alignment Marker

This block carries 16-bit words over a three-wire link whose every unit interval holds one transition symbol with a value from 0 to 4. On the transmit side it turns each accepted item into a group of seven base-5 symbols, most significant digit first. An item is a data word, an alignment marker or a sideband message. The group code is `c = s0*5^6 + s1*5^5 + ... + s6`. The 78,125 group codes are split into 65,536 data codes and 12,589 reserved codes. One reserved code is the alignment marker, symbols 3,4,4,4,4,4,3, which is code 62498. The others carry sideband indices and never collide with data.

On the receive side the block takes one symbol per valid cycle. After reset it slides a seven-symbol window over the stream until the marker appears. From the next symbol on it folds every seven symbols into a code, maps the code back, and reports one of four kinds: a data word, a marker, a sideband index, or a broken group. A symbol above 4 is flagged on its own as well. Transmit and receive are independent, so a link partner or a loopback joins the two.

Top module: `sym7_codec`

## Requirements
- R1: A data word w is sent as code w when w < 62498 and as code w+1 otherwise, written as seven symbols s0..s6 in that order, each 0..4, with code = sum of s_i*5^(6-i).
- R2: An item of kind 1 (marker) is sent as the symbols 3,4,4,4,4,4,3 (code 62498), whatever its payload.
- R3: An item of kind 2 (sideband) with index p is sent as code 65537+p. An index above 12587 is clamped to 12587, which is code 78124 (all symbols 4). Kind 0 and kind 3 are data.
- R4: The symbol output holds its value while valid and not ready. With the symbol stream always ready, items are accepted every 7 cycles with no gap between groups.
- R5: After reset the receiver is unaligned and reports nothing until the seven most recent symbols equal the marker, at any offset. It then raises `rx_aligned` and reports kind 1 with data 0 in the cycle after the marker's last symbol.
- R6: Once aligned, each seven symbols form one code. A code below 62498 reports kind 0 with data c. A code from 62499 to 65536 reports kind 0 with data c-1. The report is valid for one cycle, the cycle after the seventh symbol.
- R7: An aligned group with a code from 65537 to 78124 reports kind 2 with data c-65537.
- R8: An aligned group equal to the marker reports kind 1, and alignment is kept.
- R9: A received symbol above 4 raises `rx_sym_err` for one cycle after it is taken. The group that holds it reports kind 3 with data 0.
- R10: During reset `tx_ready` is 1 and `tx_s_valid`, `rx_valid`, `rx_aligned` and `rx_sym_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Transmit item offered |
| tx_ready | output | 1 | Transmit item taken this cycle when valid |
| tx_kind | input | 2 | 0 data, 1 marker, 2 sideband, 3 data |
| tx_payload | input | 16 | Data word or sideband index |
| tx_s_valid | output | 1 | Outgoing symbol valid |
| tx_s_ready | input | 1 | Link takes the outgoing symbol |
| tx_s_sym | output | 3 | Outgoing symbol, 0..4 |
| rx_s_valid | input | 1 | Incoming symbol valid |
| rx_s_sym | input | 3 | Incoming symbol |
| rx_valid | output | 1 | One-cycle report of a received group |
| rx_kind | output | 2 | 0 data, 1 marker, 2 sideband, 3 broken group |
| rx_data | output | 16 | Recovered word or sideband index |
| rx_aligned | output | 1 | Group boundary is known |
| rx_sym_err | output | 1 | Previous symbol was above 4 |

## Verification
The encoder and decoder are first exercised at the exact boundaries of the code split. These are words 0, 62497, 62498 and 65535, sideband index 5, and an index past the top that must clamp. A code off by one at the hole left for the marker shows up here and nowhere else. Raw symbols are driven next: junk before the marker shows that hunting ignores unaligned traffic, and a broken group shows that a bad digit poisons exactly one report. A sideband code and a marker at a group boundary show that reserved codes are told apart from data. Finally a long random mix of words, markers and sideband items runs through loopback with random backpressure, which separates correct digit ordering and holding from symbols lost or repeated at stalls.

// File: rtl/sym7_pkg.sv
`timescale 1ns/1ps
package sym7_pkg;

    localparam int SYM_W     = 3;
    localparam int GROUP_LEN = 7;
    localparam int RADIX     = 5;
    localparam int WORD_W    = 16;
    localparam int CODE_W    = 17;
    localparam int CNT_W     = $clog2(GROUP_LEN);
    localparam int HIST_LEN  = GROUP_LEN - 1;

    localparam logic [SYM_W-1:0] SYM_MAX = SYM_W'(RADIX - 1);

    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_SYNC = 2'd1,
        K_SIDE = 2'd2,
        K_BAD  = 2'd3
    } kind_e;

    // Marker digit at position pos: both ends 3, the inner five 4.
    function automatic logic [SYM_W-1:0] sync_digit(input int pos);
        return (pos == 0 || pos == GROUP_LEN - 1) ? SYM_W'(3) : SYM_W'(4);
    endfunction

    // Weight of a digit place: RADIX to the power k.
    function automatic logic [CODE_W-1:0] pow5(input logic [CNT_W-1:0] k);
        logic [CODE_W-1:0] r;
        r = CODE_W'(1);
        for (int j = 0; j < GROUP_LEN - 1; j++) begin
            if (j < int'(k)) r = CODE_W'(r * RADIX);
        end
        return r;
    endfunction

    function automatic int marker_value();
        int v;
        v = 0;
        for (int i = 0; i < GROUP_LEN; i++) v = v * RADIX + int'(sync_digit(i));
        return v;
    endfunction

    localparam int CODE_SPACE = RADIX ** GROUP_LEN;
    localparam int DATA_SPACE = 1 << WORD_W;
    localparam int SIDE_BASE  = DATA_SPACE + 1;
    localparam int SIDE_MAX   = CODE_SPACE - SIDE_BASE - 1;

    localparam logic [CODE_W-1:0] SYNC_CODE = CODE_W'(marker_value());
    localparam logic [CODE_W-1:0] SIDE_CODE = CODE_W'(SIDE_BASE);

endpackage

// File: rtl/sym7_digit.sv
`timescale 1ns/1ps
module sym7_digit
    import sym7_pkg::*;
(
    input  logic [CODE_W-1:0] rem_i,
    input  logic [CNT_W-1:0]  place_i,
    output logic [SYM_W-1:0]  digit_o,
    output logic [CODE_W-1:0] rest_o
);
    localparam int STEPS = RADIX - 1;

    logic [CODE_W-1:0] weight;
    logic [STEPS-1:0]  above;

    assign weight = pow5(place_i);

    // One comparator per nonzero digit value; the digit is how many pass.
    for (genvar m = 1; m <= STEPS; m++) begin : g_thr
        assign above[m-1] = rem_i >= CODE_W'(m * weight);
    end

    assign digit_o = SYM_W'($countones(above));
    assign rest_o  = rem_i - CODE_W'(digit_o * weight);

endmodule

// File: rtl/sym7_enc_map.sv
`timescale 1ns/1ps
module sym7_enc_map
    import sym7_pkg::*;
(
    input  kind_e             kind_i,
    input  logic [WORD_W-1:0] payload_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] wide;
    logic [CODE_W-1:0] side_idx;

    assign wide     = CODE_W'(payload_i);
    assign side_idx = (int'(payload_i) > SIDE_MAX) ? CODE_W'(SIDE_MAX) : wide;

    always_comb begin
        case (kind_i)
            K_SYNC:  code_o = SYNC_CODE;
            K_SIDE:  code_o = SIDE_CODE + side_idx;
            default: code_o = (wide < SYNC_CODE) ? wide : wide + CODE_W'(1);
        endcase
    end

endmodule

// File: rtl/sym7_dec_map.sv
`timescale 1ns/1ps
module sym7_dec_map
    import sym7_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              bad_i,
    output kind_e             kind_o,
    output logic [WORD_W-1:0] data_o
);
    always_comb begin
        if (bad_i) begin
            kind_o = K_BAD;
            data_o = '0;
        end else if (code_i == SYNC_CODE) begin
            kind_o = K_SYNC;
            data_o = '0;
        end else if (code_i < SYNC_CODE) begin
            kind_o = K_DATA;
            data_o = code_i[WORD_W-1:0];
        end else if (code_i < SIDE_CODE) begin
            kind_o = K_DATA;
            data_o = WORD_W'(code_i - CODE_W'(1));
        end else begin
            kind_o = K_SIDE;
            data_o = WORD_W'(code_i - SIDE_CODE);
        end
    end

endmodule

// File: rtl/sym7_tx.sv
`timescale 1ns/1ps
module sym7_tx
    import sym7_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  kind_e             in_kind,
    input  logic [WORD_W-1:0] in_payload,
    output logic              sym_valid,
    input  logic              sym_ready,
    output logic [SYM_W-1:0]  sym
);
    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  idx;
        logic [CODE_W-1:0] rem;
    } tx_state_t;

    tx_state_t st_q, st_d;

    logic [CODE_W-1:0] load_code;
    logic [CODE_W-1:0] rest;
    logic [SYM_W-1:0]  digit;
    logic [CNT_W-1:0]  place;
    logic              last;

    sym7_enc_map u_map (
        .kind_i    (in_kind),
        .payload_i (in_payload),
        .code_o    (load_code)
    );

    assign place = CNT_W'(GROUP_LEN - 1) - st_q.idx;

    sym7_digit u_digit (
        .rem_i   (st_q.rem),
        .place_i (place),
        .digit_o (digit),
        .rest_o  (rest)
    );

    assign last      = st_q.idx == CNT_W'(GROUP_LEN - 1);
    assign sym_valid = st_q.busy;
    assign sym       = digit;
    assign in_ready  = !st_q.busy || (sym_ready && last);

    always_comb begin
        st_d = st_q;
        if (st_q.busy && sym_ready) begin
            st_d.rem = rest;
            st_d.idx = st_q.idx + CNT_W'(1);
            if (last) st_d.busy = 1'b0;
        end
        if (in_valid && in_ready) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.rem  = load_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sym7_rx.sv
`timescale 1ns/1ps
module sym7_rx
    import sym7_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    input  logic [SYM_W-1:0]  sym,
    output logic              out_valid,
    output kind_e             out_kind,
    output logic [WORD_W-1:0] out_data,
    output logic              aligned,
    output logic              sym_err
);
    typedef struct packed {
        logic                              aligned;
        logic [CNT_W-1:0]                  cnt;
        logic [CODE_W-1:0]                 acc;
        logic                              bad;
        logic [HIST_LEN-1:0][SYM_W-1:0]    hist;
        logic                              out_v;
        kind_e                             out_k;
        logic [WORD_W-1:0]                 out_d;
        logic                              sym_err;
    } rx_state_t;

    rx_state_t st_q, st_d;

    logic              sym_bad;
    logic [SYM_W-1:0]  digit;
    logic              first;
    logic [CODE_W-1:0] acc_base;
    logic [CODE_W-1:0] acc_next;
    logic              bad_next;
    logic              hunt_hit;
    kind_e             grp_kind;
    logic [WORD_W-1:0] grp_data;

    assign sym_bad  = sym > SYM_MAX;
    assign digit    = sym_bad ? '0 : sym;
    assign first    = st_q.cnt == '0;
    assign acc_base = first ? '0 : st_q.acc;
    assign acc_next = CODE_W'(acc_base * RADIX) + CODE_W'(digit);
    assign bad_next = (!first && st_q.bad) || sym_bad;

    // Window of the six previous symbols plus the current one against the marker.
    always_comb begin
        hunt_hit = (sym == sync_digit(GROUP_LEN - 1));
        for (int i = 0; i < HIST_LEN; i++) begin
            if (st_q.hist[i] != sync_digit(i)) hunt_hit = 1'b0;
        end
    end

    sym7_dec_map u_map (
        .code_i (acc_next),
        .bad_i  (bad_next),
        .kind_o (grp_kind),
        .data_o (grp_data)
    );

    always_comb begin
        st_d         = st_q;
        st_d.out_v   = 1'b0;
        st_d.sym_err = 1'b0;
        if (sym_valid) begin
            st_d.sym_err = sym_bad;
            for (int i = 0; i < HIST_LEN - 1; i++) st_d.hist[i] = st_q.hist[i+1];
            st_d.hist[HIST_LEN-1] = sym;
            if (!st_q.aligned) begin
                if (hunt_hit) begin
                    st_d.aligned = 1'b1;
                    st_d.cnt     = '0;
                    st_d.out_v   = 1'b1;
                    st_d.out_k   = K_SYNC;
                    st_d.out_d   = '0;
                end
            end else begin
                st_d.acc = acc_next;
                st_d.bad = bad_next;
                if (st_q.cnt == CNT_W'(GROUP_LEN - 1)) begin
                    st_d.cnt   = '0;
                    st_d.out_v = 1'b1;
                    st_d.out_k = grp_kind;
                    st_d.out_d = grp_data;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_v;
    assign out_kind  = st_q.out_k;
    assign out_data  = st_q.out_d;
    assign aligned   = st_q.aligned;
    assign sym_err   = st_q.sym_err;

endmodule

// File: rtl/sym7_codec.sv
`timescale 1ns/1ps
module sym7_codec
    import sym7_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [1:0]        tx_kind,
    input  logic [WORD_W-1:0] tx_payload,
    output logic              tx_s_valid,
    input  logic              tx_s_ready,
    output logic [SYM_W-1:0]  tx_s_sym,
    input  logic              rx_s_valid,
    input  logic [SYM_W-1:0]  rx_s_sym,
    output logic              rx_valid,
    output logic [1:0]        rx_kind,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_aligned,
    output logic              rx_sym_err
);
    kind_e tx_kind_e;
    kind_e rx_kind_e;

    assign tx_kind_e = kind_e'(tx_kind);

    sym7_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (tx_valid),
        .in_ready   (tx_ready),
        .in_kind    (tx_kind_e),
        .in_payload (tx_payload),
        .sym_valid  (tx_s_valid),
        .sym_ready  (tx_s_ready),
        .sym        (tx_s_sym)
    );

    sym7_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (rx_s_valid),
        .sym       (rx_s_sym),
        .out_valid (rx_valid),
        .out_kind  (rx_kind_e),
        .out_data  (rx_data),
        .aligned   (rx_aligned),
        .sym_err   (rx_sym_err)
    );

    assign rx_kind = rx_kind_e;

endmodule

// File: rtl/sym7_codec_chk.sv
`timescale 1ns/1ps
module sym7_codec_chk
    import sym7_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tx_ready,
    input logic              tx_s_valid,
    input logic              tx_s_ready,
    input logic [SYM_W-1:0]  tx_s_sym,
    input logic              rx_s_valid,
    input logic [SYM_W-1:0]  rx_s_sym,
    input logic              rx_valid,
    input logic [1:0]        rx_kind,
    input logic [WORD_W-1:0] rx_data,
    input logic              rx_aligned,
    input logic              rx_sym_err
);
    // R1
    tx_sym_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_s_valid |-> tx_s_sym <= SYM_MAX);

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_s_valid && !tx_s_ready |=> tx_s_valid && $stable(tx_s_sym));

    // R4
    tx_idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_s_valid |-> tx_ready);

    // R5
    rx_align_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_aligned) |-> rx_valid && rx_kind == K_SYNC);

    // R6
    rx_report_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_aligned);

    // R8
    rx_keep_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_aligned |=> rx_aligned);

    // R7
    rx_side_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_kind == K_SIDE |-> int'(rx_data) <= SIDE_MAX);

    // R9
    rx_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_s_valid && rx_s_sym > SYM_MAX |=> rx_sym_err);

    // R9
    rx_bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_kind == K_BAD |-> rx_data == '0);

endmodule

bind sym7_codec sym7_codec_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_ready   (tx_ready),
    .tx_s_valid (tx_s_valid),
    .tx_s_ready (tx_s_ready),
    .tx_s_sym   (tx_s_sym),
    .rx_s_valid (rx_s_valid),
    .rx_s_sym   (rx_s_sym),
    .rx_valid   (rx_valid),
    .rx_kind    (rx_kind),
    .rx_data    (rx_data),
    .rx_aligned (rx_aligned),
    .rx_sym_err (rx_sym_err)
);

// File: tb/sym7_codec_bench.sv
`timescale 1ns/1ps
module sym7_codec_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n      = 1'b0;
    logic        tx_valid   = 1'b0;
    logic        tx_ready;
    logic [1:0]  tx_kind    = 2'd0;
    logic [15:0] tx_payload = 16'd0;
    logic        tx_s_valid;
    logic        tx_s_ready = 1'b1;
    logic [2:0]  tx_s_sym;
    logic        rx_s_valid;
    logic [2:0]  rx_s_sym;
    logic        rx_valid;
    logic [1:0]  rx_kind;
    logic [15:0] rx_data;
    logic        rx_aligned;
    logic        rx_sym_err;

    logic       lb       = 1'b0;
    logic       man_v    = 1'b0;
    logic [2:0] man_s    = 3'd0;
    logic       stall_en = 1'b0;

    assign rx_s_valid = lb ? (tx_s_valid && tx_s_ready) : man_v;
    assign rx_s_sym   = lb ? tx_s_sym : man_s;

    sym7_codec u_sym7_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_kind    (tx_kind),
        .tx_payload (tx_payload),
        .tx_s_valid (tx_s_valid),
        .tx_s_ready (tx_s_ready),
        .tx_s_sym   (tx_s_sym),
        .rx_s_valid (rx_s_valid),
        .rx_s_sym   (rx_s_sym),
        .rx_valid   (rx_valid),
        .rx_kind    (rx_kind),
        .rx_data    (rx_data),
        .rx_aligned (rx_aligned),
        .rx_sym_err (rx_sym_err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int acc_cyc = 0;
    int    sym_exp[$];
    string sym_tag[$];
    int    word_exp[$];
    string word_tag[$];

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int enc_code(input int kind, input int p);
        if (kind == 1) return 62498;
        if (kind == 2) return 65537 + ((p > 12587) ? 12587 : p);
        return (p < 62498) ? p : p + 1;
    endfunction

    function automatic int pow5i(input int k);
        int r;
        r = 1;
        for (int j = 0; j < k; j++) r = r * 5;
        return r;
    endfunction

    // Symbol scoreboard monitor (loopback phases only)
    always @(negedge clk) begin
        if (rst_n && lb && tx_s_valid && tx_s_ready) begin
            if (sym_exp.size() == 0) begin
                chk(1'b0, "R4", "symbol with nothing expected", tx_s_sym, -1);
            end else begin
                int e;
                string t;
                e = sym_exp.pop_front();
                t = sym_tag.pop_front();
                chk(int'(tx_s_sym) == e, t, "tx symbol", tx_s_sym, e);
            end
        end
    end

    // Report scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (word_exp.size() == 0) begin
                chk(1'b0, "R5", "report with nothing expected", rx_kind, -1);
            end else begin
                int e;
                string t;
                e = word_exp.pop_front();
                t = word_tag.pop_front();
                chk(int'(rx_kind) == e / 65536, t, "rx kind", rx_kind, e / 65536);
                chk(int'(rx_data) == e % 65536, t, "rx data", rx_data, e % 65536);
            end
        end
    end

    // Backpressure on the symbol stream
    always @(posedge clk) begin
        #1;
        tx_s_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    task automatic push_word(input int kind, input int data, input string t);
        word_exp.push_back(kind * 65536 + data);
        word_tag.push_back(t);
    endtask

    // Called just after a rising edge; returns just after the accepting edge.
    task automatic send(input int kind, input int p, input string stag, input string wtag);
        int code;
        bit ok;
        code = enc_code(kind, p);
        for (int i = 0; i < 7; i++) begin
            int w;
            w = pow5i(6 - i);
            sym_exp.push_back(code / w);
            sym_tag.push_back(stag);
            code = code % w;
        end
        if (kind == 1)      push_word(1, 0, wtag);
        else if (kind == 2) push_word(2, (p > 12587) ? 12587 : p, wtag);
        else                push_word(0, p, wtag);
        tx_valid   = 1'b1;
        tx_kind    = 2'(kind);
        tx_payload = 16'(p);
        do begin
            @(negedge clk);
            ok = tx_ready;
            @(posedge clk);
            #1;
        end while (!ok);
        acc_cyc  = cyc;
        tx_valid = 1'b0;
    endtask

    task automatic drive_sym(input int s);
        @(posedge clk);
        #1;
        man_v = 1'b1;
        man_s = 3'(s);
    endtask

    task automatic drive_code(input int code);
        int c;
        c = code;
        for (int i = 0; i < 7; i++) begin
            int w;
            w = pow5i(6 - i);
            drive_sym(c / w);
            c = c % w;
        end
    endtask

    task automatic drive_idle();
        @(posedge clk);
        #1;
        man_v = 1'b0;
    endtask

    task automatic wait_drain(input string t);
        for (int i = 0; i < 400 && (sym_exp.size() != 0 || word_exp.size() != 0); i++)
            @(posedge clk);
        #1;
        chk(sym_exp.size() == 0 && word_exp.size() == 0, t, "items left",
            sym_exp.size() + word_exp.size(), 0);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        tx_valid = 1'b0;
        man_v    = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(tx_ready == 1'b1,   "R10", "tx_ready in reset",   tx_ready,   1);
        chk(tx_s_valid == 1'b0, "R10", "tx_s_valid in reset", tx_s_valid, 0);
        chk(rx_valid == 1'b0,   "R10", "rx_valid in reset",   rx_valid,   0);
        chk(rx_aligned == 1'b0, "R10", "rx_aligned in reset", rx_aligned, 0);
        chk(rx_sym_err == 1'b0, "R10", "rx_sym_err in reset", rx_sym_err, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    bit done = 1'b0;

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int a0;
        int a3;

        // Phase 1: raw symbols into the receiver
        do_reset();
        lb = 1'b0;
        // R5: junk before the marker gives no report and no alignment
        drive_sym(0); drive_sym(1); drive_sym(2); drive_sym(0); drive_sym(1);
        drive_idle();
        @(negedge clk);
        chk(rx_aligned == 1'b0, "R5", "aligned before marker", rx_aligned, 0);
        push_word(1, 0, "R5");
        drive_code(62498);
        drive_idle();
        @(negedge clk);
        chk(rx_aligned == 1'b1, "R5", "aligned after marker", rx_aligned, 1);
        // R9: bad symbol inside a group
        push_word(3, 0, "R9");
        drive_sym(0); drive_sym(0); drive_sym(7); drive_sym(0);
        @(negedge clk);
        chk(rx_sym_err == 1'b1, "R9", "symbol error flag", rx_sym_err, 1);
        drive_sym(0); drive_sym(0); drive_sym(0);
        drive_idle();
        @(negedge clk);
        chk(rx_sym_err == 1'b0, "R9", "symbol error clears", rx_sym_err, 0);
        // R7: sideband code 65542 gives index 5
        push_word(2, 5, "R7");
        drive_code(65542);
        // R8: marker on a group boundary
        push_word(1, 0, "R8");
        drive_code(62498);
        // R6: codes above the marker map down by one
        push_word(0, 62498, "R6");
        drive_code(62499);
        push_word(0, 65535, "R6");
        drive_code(65536);
        push_word(0, 1234, "R6");
        drive_code(1234);
        drive_idle();
        wait_drain("R6");
        chk(rx_aligned == 1'b1, "R8", "alignment kept", rx_aligned, 1);

        // Phase 2: loopback at the code boundaries
        do_reset();
        lb = 1'b1;
        send(1, 0, "R2", "R5");
        send(0, 0, "R1", "R6");
        send(0, 62497, "R1", "R6");
        send(0, 62498, "R1", "R6");
        send(0, 65535, "R1", "R6");
        send(2, 5, "R3", "R7");
        send(2, 16000, "R3", "R7");
        send(1, 777, "R2", "R8");
        // R4: back-to-back throughput
        send(0, 100, "R1", "R6");
        a0 = acc_cyc;
        send(0, 200, "R1", "R6");
        send(0, 300, "R1", "R6");
        send(0, 400, "R1", "R6");
        a3 = acc_cyc;
        chk(a3 - a0 == 21, "R4", "cycles for three groups", a3 - a0, 21);
        wait_drain("R6");

        // Phase 3: random mix under backpressure
        stall_en = 1'b1;
        for (int n = 0; n < 60; n++) begin
            int r;
            r = $urandom_range(0, 7);
            if (r == 0)      send(1, 0, "R2", "R8");
            else if (r == 1) send(2, $urandom_range(0, 13000), "R3", "R7");
            else             send(0, $urandom_range(0, 65535), "R4", "R6");
        end
        wait_drain("R4");
        stall_en = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule